// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line back into characters. A sample strobe, pulsed once for each of sixteen equal slices of a bit period, paces all timing. The line passes through a two-flop synchronizer. A falling edge starts a candidate start bit. The candidate is accepted only if the line stays low for half a bit. The receiver then samples each data bit, the optional parity bit and the first stop bit at the middle of its slot. Every filtered line transition re-aligns the bit timing, so a sender that runs somewhat fast or slow is still read correctly.

A finished character goes to a one-entry holding stage and then to a small first-word-fall-through queue. A parity-error flag and a framing-error flag travel with each character. The host sees a data-available flag, reads the head of the queue from the output pins and removes it with a one-cycle pop. A sticky overrun flag, a queue-full flag and a break flag complete the host view. Character length and parity are configuration inputs shared with the matching transmitter. They must be held stable while a frame is in flight.

Top module: `oversample_rx`

## Requirements
- R1: After reset, dataAvail, fifoFull, overrun and breakDet are all 0.
- R2: A low level at the synchronized input that lasts 8 or more sample strobes after a falling edge is a start bit. A low pulse of 7 or fewer strobes is discarded, and no character results from it.
- R3: Data bits are taken at the middle of each bit slot, least significant bit first. cfgDataBits (5 to 9) sets their count. The character appears right-aligned in popData, with the unused upper bits at 0.
- R4: When cfgParityEn is 1, one parity bit follows the data. cfgParityOdd=0 selects even parity and 1 selects odd parity. A mismatch sets popParErr for that character. With parity off, popParErr is 0.
- R5: The first stop bit is taken at mid-slot. If it reads 0, popFrmErr is set for that character, and the character is still delivered.
- R6: breakDet is 1 while the synchronized line has been low for at least one full character time (16 strobes × (start + data + parity + one stop)). It returns to 0 once the line is sampled high.
- R7: Each line transition that stays at its new level for two consecutive strobes re-aligns the bit phase to mid-slot. A character with an edge in every bit slot is read correctly at bit periods of 14 and 18 strobes.
- R8: Characters leave in arrival order. dataAvail is 1 while at least one is queued, and popData, popParErr and popFrmErr show the oldest one. A one-cycle popEn removes it. fifoFull is 1 when all FIFO_DEPTH entries are in use.
- R9: The holding stage adds one place beyond the queue. A character that completes while both the queue and the holding stage are full is dropped and sets overrun. Overrun then stays 1 until the next pop.
- R10: All bit timing counts tickEn pulses only. With one strobe every two clocks, a 32-clock bit period is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Sample strobe, 16 per bit period |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| cfgDataBits | input | 4 | Data bits per character, 5 to 9 |
| cfgParityEn | input | 1 | Parity bit present |
| cfgParityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| popEn | input | 1 | Remove the head character |
| popData | output | 9 | Head character, right-aligned |
| popParErr | output | 1 | Parity error of the head character |
| popFrmErr | output | 1 | Framing error of the head character |
| dataAvail | output | 1 | Queue holds at least one character |
| fifoFull | output | 1 | Queue is full |
| overrun | output | 1 | A character was dropped, cleared by pop |
| breakDet | output | 1 | Line held low for a full character time |

## Verification
The bench builds the block with a FIFO_DEPTH of 4, so that five characters fill the queue and the holding stage. A sixth character then reaches the drop-and-overrun case. Character lengths of 5, 7, 8 and 9 bits are used, with even parity, odd parity and no parity. Bit periods of 14, 16, 18 and 32 clocks are driven. The off-nominal rates work only if phase re-alignment functions, and the 32-clock period tests the reduced strobe rate.

// File: rtl/rx_pkg.sv
package rx_pkg;

  localparam int OSR       = 16;
  localparam int RX_DATA_W = 9;
  localparam int MIN_BITS  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rxState_t;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic startOk;
    logic dataSample;
    logic paritySample;
    logic stopSample;
  } rxStrobe_t;

  typedef struct packed {
    logic                 frmErr;
    logic                 parErr;
    logic [RX_DATA_W-1:0] data;
  } rxEntry_t;

  function automatic logic [3:0] clampBits(input logic [3:0] req);
    if (req < 4'(MIN_BITS))       return 4'(MIN_BITS);
    else if (req > 4'(RX_DATA_W)) return 4'(RX_DATA_W);
    else                          return req;
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       rxSync,
  input  logic [3:0] cfgDataBits,
  input  logic       cfgParityEn,
  output rxStrobe_t  strobe,
  output logic       breakDet
);
  localparam int PH_W     = $clog2(OSR);
  localparam int HALF     = OSR / 2;
  localparam int CNT_W    = $clog2(OSR * (RX_DATA_W + 3) + 1);
  // phase loaded after an accepted edge so that the sample lands mid-slot
  localparam logic [PH_W-1:0] RESYNC_PH = PH_W'(HALF + 2);
  localparam logic [PH_W-1:0] LAST_PH   = PH_W'(OSR - 1);

  rxState_t          state;
  logic [PH_W-1:0]   phase;
  logic [3:0]        bitCnt;
  logic [1:0]        hist;
  logic [CNT_W-1:0]  lowCnt;
  logic [CNT_W-1:0]  charTicks;
  logic [3:0]        effBits;
  logic              fallEdge;
  logic              edgeOk;
  logic              atSample;

  assign effBits   = clampBits(cfgDataBits);
  assign charTicks = CNT_W'((32'(effBits) + 2 + 32'(cfgParityEn)) * OSR);
  assign fallEdge  = !rxSync && hist[0];
  // a new level counts once it has been seen on two strobes in a row
  assign edgeOk    = (rxSync == hist[0]) && (hist[0] != hist[1]);
  assign atSample  = (phase == LAST_PH);

  always_comb begin
    strobe = '0;
    if (tickEn) begin
      unique case (state)
        ST_START:  strobe.startOk      = !rxSync && (phase == PH_W'(HALF - 1));
        ST_DATA:   strobe.dataSample   = atSample;
        ST_PARITY: strobe.paritySample = atSample;
        ST_STOP:   strobe.stopSample   = atSample;
        default:   strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      phase  <= '0;
      bitCnt <= '0;
      hist   <= 2'b11;
    end else if (tickEn) begin
      hist <= {hist[0], rxSync};
      unique case (state)
        ST_IDLE: begin
          if (fallEdge) begin
            state <= ST_START;
            phase <= PH_W'(1);
          end
        end
        ST_START: begin
          if (rxSync) begin
            state <= ST_IDLE;
          end else if (phase == PH_W'(HALF - 1)) begin
            state  <= ST_DATA;
            phase  <= '0;
            bitCnt <= '0;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        ST_DATA, ST_PARITY, ST_STOP: begin
          if (atSample) begin
            phase <= '0;
            if (state == ST_DATA) begin
              bitCnt <= bitCnt + 4'd1;
              if (bitCnt == effBits - 4'd1)
                state <= cfgParityEn ? ST_PARITY : ST_STOP;
            end else if (state == ST_PARITY) begin
              state <= ST_STOP;
            end else begin
              state <= ST_IDLE;
            end
          end else if (edgeOk) begin
            phase <= RESYNC_PH;
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowCnt <= '0;
    else if (tickEn) begin
      if (rxSync)              lowCnt <= '0;
      else if (lowCnt < charTicks) lowCnt <= lowCnt + CNT_W'(1);
    end
  end

  assign breakDet = (lowCnt >= charTicks);
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxSync,
  input  rxStrobe_t            strobe,
  input  logic [3:0]           cfgDataBits,
  input  logic                 cfgParityEn,
  input  logic                 cfgParityOdd,
  input  logic                 popEn,
  output logic [RX_DATA_W-1:0] popData,
  output logic                 popParErr,
  output logic                 popFrmErr,
  output logic                 dataAvail,
  output logic                 fifoFull,
  output logic                 overrun
);
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  logic [RX_DATA_W-1:0] shiftReg;
  logic                 parAcc;
  logic [3:0]           effBits;
  rxEntry_t             newEntry;
  rxEntry_t             holdEntry;
  logic                 holdValid;
  logic                 moveHold;
  logic                 doPop;
  rxEntry_t             mem [FIFO_DEPTH];
  logic [AW:0]          wrPtr;
  logic [AW:0]          rdPtr;
  logic                 empty;

  assign effBits = clampBits(cfgDataBits);

  // serial to parallel with running parity
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strobe.startOk) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strobe.dataSample) begin
      shiftReg <= {rxSync, shiftReg[RX_DATA_W-1:1]};
      parAcc   <= parAcc ^ rxSync;
    end else if (strobe.paritySample) begin
      parAcc   <= parAcc ^ rxSync;
    end
  end

  always_comb begin
    newEntry.data   = shiftReg >> (4'(RX_DATA_W) - effBits);
    newEntry.parErr = cfgParityEn && (parAcc ^ cfgParityOdd);
    newEntry.frmErr = !rxSync;
  end

  assign empty     = (wrPtr == rdPtr);
  assign fifoFull  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);
  assign dataAvail = !empty;
  assign moveHold  = holdValid && !fifoFull;
  assign doPop     = popEn && !empty;

  // holding stage between shifter and queue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdEntry <= '0;
      overrun   <= 1'b0;
    end else begin
      if (strobe.stopSample && holdValid && !moveHold) begin
        overrun <= 1'b1;
      end else begin
        if (doPop) overrun <= 1'b0;
        if (strobe.stopSample) begin
          holdEntry <= newEntry;
          holdValid <= 1'b1;
        end else if (moveHold) begin
          holdValid <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (moveHold) mem[wrPtr[AW-1:0]] <= holdEntry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (moveHold) wrPtr <= wrPtr + (AW+1)'(1);
      if (doPop)    rdPtr <= rdPtr + (AW+1)'(1);
    end
  end

  always_comb begin
    if (empty) begin
      popData   = '0;
      popParErr = 1'b0;
      popFrmErr = 1'b0;
    end else begin
      popData   = mem[rdPtr[AW-1:0]].data;
      popParErr = mem[rdPtr[AW-1:0]].parErr;
      popFrmErr = mem[rdPtr[AW-1:0]].frmErr;
    end
  end
endmodule

// File: rtl/oversample_rx.sv
module oversample_rx
  import rx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickEn,
  input  logic                 rxLine,
  input  logic [3:0]           cfgDataBits,
  input  logic                 cfgParityEn,
  input  logic                 cfgParityOdd,
  input  logic                 popEn,
  output logic [RX_DATA_W-1:0] popData,
  output logic                 popParErr,
  output logic                 popFrmErr,
  output logic                 dataAvail,
  output logic                 fifoFull,
  output logic                 overrun,
  output logic                 breakDet
);
  logic      rxSync;
  rxStrobe_t ctrlStrobe;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(rxLine), .dout(rxSync)
  );

  rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxSync(rxSync),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .strobe(ctrlStrobe), .breakDet(breakDet)
  );

  rx_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .rxSync(rxSync), .strobe(ctrlStrobe),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .popEn(popEn),
    .popData(popData), .popParErr(popParErr), .popFrmErr(popFrmErr),
    .dataAvail(dataAvail), .fifoFull(fifoFull), .overrun(overrun)
  );
endmodule

// File: rtl/rx_chk.sv
module rx_chk
  import rx_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 tickEn,
  input logic                 rxSync,
  input rxStrobe_t            strobe,
  input logic                 popEn,
  input logic [RX_DATA_W-1:0] popData,
  input logic                 dataAvail,
  input logic                 fifoFull,
  input logic                 overrun,
  input logic                 breakDet
);
  // R8
  full_has_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> dataAvail);

  // R8
  avail_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataAvail) |-> $past(popEn));

  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataAvail && !popEn) |=> $stable(popData));

  // R9
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(fifoFull));

  // R6
  break_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakDet) |-> !$past(rxSync));

  // R10
  strobe_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe) |-> tickEn);
endmodule

bind oversample_rx rx_chk u_rx_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxSync(rxSync),
  .strobe(ctrlStrobe), .popEn(popEn), .popData(popData),
  .dataAvail(dataAvail), .fifoFull(fifoFull), .overrun(overrun),
  .breakDet(breakDet)
);

// File: tb/test_oversample_rx.sv
module test_oversample_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLK    = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       slowTick = 1'b0;
  logic       rxLine = 1'b1;
  logic [3:0] cfgDataBits = 4'd8;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       popEn = 1'b0;
  logic [8:0] popData;
  logic       popParErr, popFrmErr, dataAvail, fifoFull, overrun, breakDet;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;

  oversample_rx #(.FIFO_DEPTH(4)) i_oversample_rx (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rxLine(rxLine),
    .cfgDataBits(cfgDataBits), .cfgParityEn(cfgParityEn),
    .cfgParityOdd(cfgParityOdd), .popEn(popEn), .popData(popData),
    .popParErr(popParErr), .popFrmErr(popFrmErr), .dataAvail(dataAvail),
    .fifoFull(fifoFull), .overrun(overrun), .breakDet(breakDet)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) tickEn <= slowTick ? ~tickEn : 1'b1;

  task automatic check(input string req, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] d, input int nb, input bit pflip,
                           input bit stopv, input int bc);
    logic p = 1'b0;
    rxLine = 1'b0; idle(bc);
    for (int i = 0; i < nb; i++) begin
      rxLine = d[i]; p ^= d[i]; idle(bc);
    end
    if (cfgParityEn) begin
      rxLine = p ^ cfgParityOdd ^ pflip; idle(bc);
    end
    rxLine = stopv; idle(bc);
    rxLine = 1'b1; idle(8);
  endtask

  task automatic popCheck(input string req, input int d, input int pe, input int fe);
    check({req, " avail"}, dataAvail, 1);
    check({req, " data"}, popData, d);
    check({req, " parErr"}, popParErr, pe);
    check({req, " frmErr"}, popFrmErr, fe);
    popEn = 1'b1; idle(1);
    popEn = 1'b0; idle(2);
  endtask

  task automatic testReset();
    check("R1 dataAvail", dataAvail, 0);
    check("R1 fifoFull", fifoFull, 0);
    check("R1 overrun", overrun, 0);
    check("R1 breakDet", breakDet, 0);
  endtask

  task automatic testBasic();
    cfgDataBits = 4'd8; cfgParityEn = 1'b0;
    sendFrame(9'h0A5, 8, 0, 1, BIT_CLK);
    popCheck("R3 8N1 A5", 'hA5, 0, 0);
    sendFrame(9'h03C, 8, 0, 1, BIT_CLK);
    popCheck("R3 8N1 3C", 'h3C, 0, 0);
    check("R8 empty after pops", dataAvail, 0);
  endtask

  task automatic testWidths();
    cfgDataBits = 4'd5;
    sendFrame(9'h015, 5, 0, 1, BIT_CLK);
    popCheck("R3 5-bit", 'h15, 0, 0);
    cfgDataBits = 4'd9;
    sendFrame(9'h1A7, 9, 0, 1, BIT_CLK);
    popCheck("R3 9-bit", 'h1A7, 0, 0);
    cfgDataBits = 4'd8;
  endtask

  task automatic testGlitch();
    rxLine = 1'b0; idle(7); rxLine = 1'b1; idle(220);
    check("R2 7-strobe pulse ignored", dataAvail, 0);
    rxLine = 1'b0; idle(8); rxLine = 1'b1; idle(220);
    popCheck("R2 8-strobe start", 'hFF, 0, 0);
  endtask

  task automatic testParity();
    cfgDataBits = 4'd7; cfgParityEn = 1'b1; cfgParityOdd = 1'b0;
    sendFrame(9'h05B, 7, 0, 1, BIT_CLK);
    popCheck("R4 even ok", 'h5B, 0, 0);
    sendFrame(9'h05B, 7, 1, 1, BIT_CLK);
    popCheck("R4 even bad", 'h5B, 1, 0);
    cfgParityOdd = 1'b1;
    sendFrame(9'h032, 7, 0, 1, BIT_CLK);
    popCheck("R4 odd ok", 'h32, 0, 0);
    sendFrame(9'h032, 7, 1, 1, BIT_CLK);
    popCheck("R4 odd bad", 'h32, 1, 0);
    cfgDataBits = 4'd8; cfgParityEn = 1'b0; cfgParityOdd = 1'b0;
  endtask

  task automatic testFraming();
    sendFrame(9'h0C6, 8, 0, 0, BIT_CLK);
    popCheck("R5 stop low", 'hC6, 0, 1);
  endtask

  task automatic testBreak();
    rxLine = 1'b0; idle(220);
    check("R6 break while low", breakDet, 1);
    rxLine = 1'b1; idle(10);
    check("R6 break clears", breakDet, 0);
    popCheck("R5 break char", 'h00, 0, 1);
  endtask

  task automatic testResync();
    sendFrame(9'h055, 8, 0, 1, 18);
    popCheck("R7 slow sender", 'h55, 0, 0);
    sendFrame(9'h0AA, 8, 0, 1, 14);
    popCheck("R7 fast sender", 'hAA, 0, 0);
  endtask

  task automatic testOverrun();
    for (int i = 1; i <= 5; i++) sendFrame(9'(i), 8, 0, 1, BIT_CLK);
    check("R8 full", fifoFull, 1);
    check("R9 no overrun yet", overrun, 0);
    sendFrame(9'h006, 8, 0, 1, BIT_CLK);
    check("R9 overrun set", overrun, 1);
    popCheck("R8 order 1", 1, 0, 0);
    check("R9 overrun cleared by pop", overrun, 0);
    for (int i = 2; i <= 5; i++) popCheck("R8 order", i, 0, 0);
    check("R9 sixth dropped", dataAvail, 0);
  endtask

  task automatic testSlowTick();
    slowTick = 1'b1; idle(2);
    sendFrame(9'h0C3, 8, 0, 1, 32);
    popCheck("R10 half-rate strobe", 'hC3, 0, 0);
    slowTick = 1'b0; idle(2);
  endtask

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(5);
    testReset();
    testBasic();
    testWidths();
    testGlitch();
    testParity();
    testFraming();
    testBreak();
    testResync();
    testOverrun();
    testSlowTick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule